// File: doc/BRIEF.md
# Level-Interrupt GPIO Bank

This block is a register-mapped controller for twelve general-purpose I/O lines. A host writes an output value register and a per-line drive-enable register. It reads back the pin levels after they pass through a two-stage synchroniser. Each line can also raise a level-sensitive interrupt. The active level of each line is chosen by one bit in one of two polarity registers.

A line whose synchronised level equals its chosen active level sets its bit in a pending register. This happens whether or not the line is enabled. A pending bit is acknowledged by writing a 1 to it. If the line is still at its active level, the bit comes back on the following cycle, so software must remove the cause before it acknowledges. The pending bits are ANDed with an enable mask, and the result is OR-reduced into a single interrupt output. A 32-bit routing register is stored and read back, but it controls nothing inside the block.

The host bus is a single-cycle strobe with a 5-bit byte address, a write enable and 32-bit write data. Read data is registered. Every cycle, the read port returns the register selected by the address on the previous cycle.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every register reads 0, and pin_out, pin_oe and irq are 0.
- R2: Offset 0x00 (output value) drives pin_out and offset 0x04 (drive enable) drives pin_oe, bit n for line n. Both read back with bits 31..12 as zero.
- R3: Offset 0x08 returns each pin level after two clock stages of synchronisation. Read data is registered one more cycle. A write to 0x08 is ignored.
- R4: The polarity bit for line n sits at bit 4*(n mod 8). It is held at offset 0x10 for lines 0..7 and at offset 0x18 for lines 8..11. Both registers store and return all 32 bits, and bits at other positions have no effect.
- R5: Polarity bit 0 makes a line active when its level is high, and polarity bit 1 makes it active when low. A pending bit (offset 0x0C, bit n) sets whenever its line is active, whatever the enable mask holds.
- R6: Writing 1 to a bit of offset 0x0C clears that pending bit, and writing 0 leaves it unchanged. A cleared bit whose line is still active is set again on the next cycle. A cleared bit whose line is inactive stays clear.
- R7: irq is 1 exactly when some pending bit and the same bit of the enable register (offset 0x14, 1 = unmasked) are both 1. The enable register reads back with bits 31..12 as zero.
- R8: Offset 0x1C stores and returns all 32 bits, and writing it changes neither pin_out, pin_oe nor irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output values |
| pin_oe | output | 12 | Per-line drive enable |
| irq | output | 1 | Combined level interrupt |

## Verification
The assertions assume a single write per cycle, presented for exactly one clock with an aligned address. They also assume pin levels reach the logic only through the synchroniser, so pending bits can be related to the previous cycle's detect vector. The bench changes pins and bus signals only on falling edges. It holds pins low through reset, so no line is active when reset is released. Each pin change is followed by enough cycles to cover both synchroniser stages and the pending register before any result is sampled.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_DOUT = 5'h00;
  localparam logic [REG_AW-1:0] OFS_DOE  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_DIN  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_PEND = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_POL0 = 5'h10;
  localparam logic [REG_AW-1:0] OFS_IEN  = 5'h14;
  localparam logic [REG_AW-1:0] OFS_POL1 = 5'h18;
  localparam logic [REG_AW-1:0] OFS_ROUT = 5'h1C;

  localparam int LINES_PER_POL = 8;
  localparam int POL_STRIDE    = 4;

  // which polarity register holds line n
  function automatic int pol_reg_sel(input int n);
    return n / LINES_PER_POL;
  endfunction

  // bit position of line n inside its polarity register
  function automatic int pol_bit_pos(input int n);
    return POL_STRIDE * (n % LINES_PER_POL);
  endfunction

  // a line is active when its level differs from its polarity bit
  function automatic logic lvl_hit(input logic lvl, input logic pol);
    return lvl ^ pol;
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq #(
  parameter int NUM_LINES = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lvl_in,
  input  logic [NUM_LINES-1:0] pol_vec,
  input  logic [NUM_LINES-1:0] clr_mask,
  input  logic [NUM_LINES-1:0] ien,
  output logic [NUM_LINES-1:0] pend,
  output logic [NUM_LINES-1:0] hit,
  output logic                 irq
);
  import pinbank_pkg::*;

  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] pend_d;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_det
    assign hit[n] = lvl_hit(lvl_in[n], pol_vec[n]);
  end

  // clear wins in its own cycle; a still-active line re-latches next cycle
  assign pend_d = (pend_q | hit) & ~clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;
  assign irq  = |(pend_q & ien);

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((pend_q & $past(clr_mask)) == '0));

  // R5
  active_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & ~clr_mask)) |=>
      ((pend_q & $past(hit & ~clr_mask)) == $past(hit & ~clr_mask)));

  // R5
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(hit)) == '0));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs #(
  parameter int NUM_LINES = 12,
  parameter int DATA_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [pinbank_pkg::REG_AW-1:0] addr,
  input  logic                           wr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_LINES-1:0]           din,
  input  logic [NUM_LINES-1:0]           pend,
  output logic [NUM_LINES-1:0]           dout,
  output logic [NUM_LINES-1:0]           doe,
  output logic [NUM_LINES-1:0]           ien,
  output logic [NUM_LINES-1:0]           pol_vec,
  output logic [NUM_LINES-1:0]           clr_mask,
  output logic [DATA_W-1:0]              rdata
);
  import pinbank_pkg::*;

  localparam int PAD = DATA_W - NUM_LINES;

  logic [NUM_LINES-1:0] dout_q, doe_q, ien_q;
  logic [DATA_W-1:0]    pol0_q, pol1_q, rout_q;
  logic [DATA_W-1:0]    rd_val, rdata_q;
  logic                 we_dout, we_doe, we_ien, we_pol0, we_pol1, we_rout, we_pend;

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_LINES-1:0] v);
    return {{PAD{1'b0}}, v};
  endfunction

  assign we_dout = wr && (addr == OFS_DOUT);
  assign we_doe  = wr && (addr == OFS_DOE);
  assign we_ien  = wr && (addr == OFS_IEN);
  assign we_pol0 = wr && (addr == OFS_POL0);
  assign we_pol1 = wr && (addr == OFS_POL1);
  assign we_rout = wr && (addr == OFS_ROUT);
  assign we_pend = wr && (addr == OFS_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      doe_q  <= '0;
      ien_q  <= '0;
      pol0_q <= '0;
      pol1_q <= '0;
      rout_q <= '0;
    end else begin
      if (we_dout) dout_q <= wdata[NUM_LINES-1:0];
      if (we_doe)  doe_q  <= wdata[NUM_LINES-1:0];
      if (we_ien)  ien_q  <= wdata[NUM_LINES-1:0];
      if (we_pol0) pol0_q <= wdata;
      if (we_pol1) pol1_q <= wdata;
      if (we_rout) rout_q <= wdata;
    end
  end

  // polarity bits picked from nibble-spaced positions of the two registers
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_pol
    localparam int SEL = pol_reg_sel(n);
    localparam int POS = pol_bit_pos(n);
    if (SEL == 0) begin : g_lo
      assign pol_vec[n] = pol0_q[POS];
    end else begin : g_hi
      assign pol_vec[n] = pol1_q[POS];
    end
  end

  assign clr_mask = we_pend ? wdata[NUM_LINES-1:0] : '0;

  always_comb begin
    case (addr)
      OFS_DOUT: rd_val = widen(dout_q);
      OFS_DOE:  rd_val = widen(doe_q);
      OFS_DIN:  rd_val = widen(din);
      OFS_PEND: rd_val = widen(pend);
      OFS_POL0: rd_val = pol0_q;
      OFS_IEN:  rd_val = widen(ien_q);
      OFS_POL1: rd_val = pol1_q;
      OFS_ROUT: rd_val = rout_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_val;
  end

  assign dout  = dout_q;
  assign doe   = doe_q;
  assign ien   = ien_q;
  assign rdata = rdata_q;

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_dout |=> $stable(dout_q));

  // R8
  rout_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_rout |=> ($stable(dout_q) && $stable(doe_q) && $stable(ien_q)));
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl #(
  parameter int NUM_LINES = 12,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq
);
  logic [NUM_LINES-1:0] lvl_sync;
  logic [NUM_LINES-1:0] pend_w, hit_w, ien_w, pol_w, clr_w;

  pinbank_sync #(.WIDTH(NUM_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
  );

  pinbank_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .din(lvl_sync), .pend(pend_w), .dout(pin_out), .doe(pin_oe), .ien(ien_w),
    .pol_vec(pol_w), .clr_mask(clr_w), .rdata(bus_rdata)
  );

  pinbank_irq #(.NUM_LINES(NUM_LINES)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl_in(lvl_sync), .pol_vec(pol_w),
    .clr_mask(clr_w), .ien(ien_w), .pend(pend_w), .hit(hit_w), .irq(irq)
  );

  // R7
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_w != '0));
endmodule

// File: tb/sim_pinbank_ctrl.sv
module sim_pinbank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_out, pin_oe;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pinbank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 32; a += 4) begin
      rd_reg(a[4:0], v);
      chk($sformatf("R1 reg %02h after reset", a), v, 32'h0);
    end
    chk("R1 pin_out", {20'h0, pin_out}, 32'h0);
    chk("R1 pin_oe", {20'h0, pin_oe}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_outputs();
    logic [31:0] v;
    wr_reg(5'h00, 32'hFFFF_FA5C);
    chk("R2 pin_out", {20'h0, pin_out}, 32'h0000_0A5C);
    rd_reg(5'h00, v);
    chk("R2 out readback", v, 32'h0000_0A5C);
    wr_reg(5'h04, 32'hFFFF_F0F0);
    chk("R2 pin_oe", {20'h0, pin_oe}, 32'h0000_00F0);
    rd_reg(5'h04, v);
    chk("R2 oe readback", v, 32'h0000_00F0);
  endtask

  task automatic t_input();
    logic [31:0] v;
    @(negedge clk);
    pin_in = 12'h3C5;
    rd_reg(5'h08, v);
    chk("R3 two-stage latency, old level", v, 32'h0);
    rd_reg(5'h08, v);
    chk("R3 synchronised level", v, 32'h0000_03C5);
    wr_reg(5'h08, 32'hFFFF_FFFF);
    rd_reg(5'h08, v);
    chk("R3 write to input ignored", v, 32'h0000_03C5);
    @(negedge clk);
    pin_in = 12'h000;
    settle();
    wr_reg(5'h0C, 32'h0000_0FFF);
    rd_reg(5'h0C, v);
    chk("R6 cleared after source gone", v, 32'h0);
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    // lines 0,5,7 low-active (bits 0,20,28); bits 21,25 are not line positions
    wr_reg(5'h10, 32'h1230_0001);
    // line 11 low-active (bit 12); bit 31 not a line position
    wr_reg(5'h18, 32'h8000_1000);
    settle();
    rd_reg(5'h0C, v);
    chk("R4 R5 low-active lines pending", v, 32'h0000_08A1);
    rd_reg(5'h10, v);
    chk("R4 pol0 full readback", v, 32'h1230_0001);
    rd_reg(5'h18, v);
    chk("R4 pol1 full readback", v, 32'h8000_1000);
    wr_reg(5'h0C, 32'h0000_0FFF);
    rd_reg(5'h0C, v);
    chk("R6 re-latch while active", v, 32'h0000_08A1);
    wr_reg(5'h10, 32'h0);
    wr_reg(5'h18, 32'h0);
    settle();
    wr_reg(5'h0C, 32'h0000_0FFF);
    rd_reg(5'h0C, v);
    chk("R5 high-active with pins low", v, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    @(negedge clk);
    pin_in = 12'h00F;
    settle();
    rd_reg(5'h0C, v);
    chk("R5 high-active lines pending", v, 32'h0000_000F);
    @(negedge clk);
    pin_in = 12'h003;
    settle();
    rd_reg(5'h0C, v);
    chk("R6 latched after source drops", v, 32'h0000_000F);
    wr_reg(5'h0C, 32'h0000_0004);
    rd_reg(5'h0C, v);
    chk("R6 single bit clear", v, 32'h0000_000B);
    wr_reg(5'h0C, 32'h0000_0000);
    rd_reg(5'h0C, v);
    chk("R6 zero write no effect", v, 32'h0000_000B);
    wr_reg(5'h14, 32'h0000_0001);
    chk("R7 irq with enabled pending", {31'h0, irq}, 32'h1);
    wr_reg(5'h0C, 32'h0000_0001);
    chk("R6 cleared in cycle after write", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R6 re-set one cycle later", {31'h0, irq}, 32'h1);
    wr_reg(5'h0C, 32'h0000_0008);
    rd_reg(5'h0C, v);
    chk("R6 inactive bit stays clear", v, 32'h0000_0003);
    wr_reg(5'h14, 32'h0);
    @(negedge clk);
    pin_in = 12'h000;
    settle();
    wr_reg(5'h0C, 32'h0000_0FFF);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    @(negedge clk);
    pin_in = 12'h800;
    settle();
    rd_reg(5'h0C, v);
    chk("R5 pending while masked", v, 32'h0000_0800);
    chk("R7 masked irq low", {31'h0, irq}, 32'h0);
    wr_reg(5'h14, 32'h0000_0400);
    chk("R7 other line enabled, irq low", {31'h0, irq}, 32'h0);
    wr_reg(5'h14, 32'h0000_0800);
    chk("R7 matching enable raises irq", {31'h0, irq}, 32'h1);
    @(negedge clk);
    pin_in = 12'h000;
    settle();
    wr_reg(5'h0C, 32'h0000_0800);
    chk("R7 irq drops after clear", {31'h0, irq}, 32'h0);
    wr_reg(5'h14, 32'hFFFF_FFFF);
    rd_reg(5'h14, v);
    chk("R7 enable readback width", v, 32'h0000_0FFF);
    chk("R7 all enabled, nothing pending", {31'h0, irq}, 32'h0);
    wr_reg(5'h14, 32'h0);
  endtask

  task automatic t_rout();
    logic [31:0] v;
    wr_reg(5'h00, 32'h0000_05A5);
    wr_reg(5'h04, 32'h0000_0FFF);
    wr_reg(5'h1C, 32'hDEAD_BEEF);
    rd_reg(5'h1C, v);
    chk("R8 routing readback", v, 32'hDEAD_BEEF);
    chk("R8 pin_out untouched", {20'h0, pin_out}, 32'h0000_05A5);
    chk("R8 pin_oe untouched", {20'h0, pin_oe}, 32'h0000_0FFF);
    chk("R8 irq untouched", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_outputs();
    t_input();
    t_polarity();
    t_w1c();
    t_irq();
    t_rout();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule